// File: doc/BRIEF.md
# Input-Change Interrupt Flag Array

This block keeps the last known value of every input port of up to 64 remote I/O stations, each station having four 8-bit ports. When the link side delivers a new byte for a port, the block stores it and compares it with the value it replaces. If monitoring is enabled for that port and the value differs, a sticky change flag is raised. An active-low interrupt line stays asserted toward the host for as long as any flag is set.

The host reaches the stored port bytes, the per-port monitor enables and the sticky flags through a byte-wide, byte-addressed window with a 9-bit address. Each enable or flag byte covers two stations: the low nibble belongs to the even station and the high nibble to the odd one, and bit n of a nibble stands for port n. The host acknowledges a change by writing ones to the matching flag bits. Host reads are registered, so read data follows the request by one cycle.

Top module: `icf_irq_array`

## Requirements
- R1: After reset every port byte, enable bit and flag bit is zero, irq_no is high, and any read returns 00h.
- R2: Port byte (station d, port p) lives at address 100h + 4*d + p. A link update stores upd_data_i there, and a host write there stores cpu_wdata_i without touching any flag. When both hit the same byte in one cycle, the link value is kept.
- R3: Monitor enables for stations 2k and 2k+1 live at address 0C0h + k. Bit p (0..3) is port p of station 2k and bit 4+p is port p of station 2k+1. The whole byte is readable and writable.
- R4: A flag bit sets at the clock edge that stores a link update whose port is enabled (enable state before that edge) and whose new byte differs from the stored one. An equal value, or an update to a disabled port, sets nothing.
- R5: Flags use the R3 bit packing at address 0E0h + k. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged.
- R6: When a flag bit is set and cleared by a host write in the same cycle, it ends up set.
- R7: irq_no is low whenever at least one flag bit is set and high otherwise. It follows the flags with no added register stage.
- R8: Addresses 000h to 0BFh hold nothing in this block. Writes there change no state, and reads there return 00h.
- R9: Read data appears on cpu_rdata_o in the cycle after cpu_re_i is sampled high. It shows the state before that edge, so a same-cycle update to the byte being read is not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 9 | Host byte address |
| cpu_wdata_i | input | 8 | Host write data |
| cpu_we_i | input | 1 | Host write strobe |
| cpu_re_i | input | 1 | Host read strobe |
| cpu_rdata_o | output | 8 | Host read data, one cycle after the read strobe |
| upd_valid_i | input | 1 | Link-side port update valid |
| upd_dev_i | input | 6 | Station number of the update |
| upd_port_i | input | 2 | Port number of the update |
| upd_data_i | input | 8 | New port value |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A flag set or cleared at a rising edge shows on irq_no straight after that edge. A read issued in one cycle is due on cpu_rdata_o after the next edge. The bench model applies each cycle's stimulus at the rising edge, keeping the pre-edge value it owes for any read. It compares irq_no and the owed read byte at the following falling edge, so every result is checked in exactly the cycle it becomes due. Directed cases cover same-cycle set and clear, same-byte link and host writes, and a read that races an update. A long stretch of random traffic follows them.

// File: rtl/icf_pkg.sv
package icf_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;
  localparam int PORTS  = 4;
  // window bases; each is aligned to its window size so low address bits index directly
  localparam logic [ADDR_W:0] ENA_BASE = 10'h0C0;
  localparam logic [ADDR_W:0] FLG_BASE = 10'h0E0;
  localparam logic [ADDR_W:0] PRT_BASE = 10'h100;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_ENA,
    RG_FLG,
    RG_PRT
  } region_e;
endpackage

// File: rtl/icf_port_store.sv
module icf_port_store
  import icf_pkg::*;
#(
  parameter  int NBYTES = 256,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              upd_valid_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [BYTE_W-1:0] upd_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              chg_o,
  output logic [IDX_W-1:0]  chg_idx_o
);
  logic [BYTE_W-1:0] mem_q [NBYTES];

  // link update written last: wins on the same byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) mem_q[i] <= '0;
    end else begin
      if (wr_en_i)     mem_q[wr_idx_i]  <= wr_data_i;
      if (upd_valid_i) mem_q[upd_idx_i] <= upd_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign chg_o     = upd_valid_i && (upd_data_i != mem_q[upd_idx_i]);
  assign chg_idx_o = upd_idx_i;

  // R2: link update lands in its byte
  a_r2_upd_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (mem_q[$past(upd_idx_i)] == $past(upd_data_i)));

  // R2: host write lands unless the link hits the same byte
  a_r2_host_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(upd_valid_i && upd_idx_i == wr_idx_i))
      |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/icf_flag_bank.sv
module icf_flag_bank
  import icf_pkg::*;
#(
  parameter  int NBITS = 256,
  localparam int IDX_W = $clog2(NBITS),
  localparam int NGRP  = NBITS / BYTE_W,
  localparam int SEL_W = $clog2(NGRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_we_i,
  input  logic              flg_we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              chg_i,
  input  logic [IDX_W-1:0]  chg_idx_i,
  output logic [NBITS-1:0]  ena_o,
  output logic [NBITS-1:0]  flg_o,
  output logic              any_o
);
  logic [BYTE_W-1:0] en_q [NGRP];
  logic [NBITS-1:0]  flg_q, set_vec, clr_vec;

  for (genvar g = 0; g < NGRP; g++) begin : g_ena
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      en_q[g] <= '0;
      else if (ena_we_i && sel_i == g)  en_q[g] <= wdata_i;
    end
    assign ena_o[g*BYTE_W +: BYTE_W] = en_q[g];
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (chg_i && ena_o[chg_idx_i]) set_vec[chg_idx_i] = 1'b1;
    if (flg_we_i) clr_vec[sel_i*BYTE_W +: BYTE_W] = wdata_i;
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_vec) | set_vec;
  end

  assign flg_o = flg_q;
  assign any_o = |flg_q;

  // checker state for the clear property
  logic              clr_chk_q;
  logic [SEL_W-1:0]  clr_sel_q;
  logic [BYTE_W-1:0] clr_mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_chk_q  <= 1'b0;
      clr_sel_q  <= '0;
      clr_mask_q <= '0;
    end else begin
      clr_chk_q  <= flg_we_i && !chg_i;
      clr_sel_q  <= sel_i;
      clr_mask_q <= wdata_i;
    end
  end

  // R4
  a_r4_set_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && ena_o[chg_idx_i] && !flg_we_i) |=> flg_q[$past(chg_idx_i)]);

  // R4: no new flag without a change event
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_i |=> ($countones(flg_q) <= $countones($past(flg_q))));

  // R5
  a_r5_clear_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_chk_q |-> ((flg_q[clr_sel_q*BYTE_W +: BYTE_W] & clr_mask_q) == '0));

  // R6
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && ena_o[chg_idx_i] && flg_we_i) |=> flg_q[$past(chg_idx_i)]);
endmodule

// File: rtl/icf_irq_array.sv
module icf_irq_array
  import icf_pkg::*;
#(
  parameter  int NUM_DEV = 64,
  localparam int DEV_W   = $clog2(NUM_DEV),
  localparam int NBITS   = NUM_DEV * PORTS,
  localparam int IDX_W   = $clog2(NBITS),
  localparam int SEL_W   = $clog2(NBITS / BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [BYTE_W-1:0] cpu_wdata_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  output logic [BYTE_W-1:0] cpu_rdata_o,
  input  logic              upd_valid_i,
  input  logic [DEV_W-1:0]  upd_dev_i,
  input  logic [1:0]        upd_port_i,
  input  logic [BYTE_W-1:0] upd_data_i,
  output logic              irq_no
);
  localparam logic [ADDR_W:0] ENA_END = ENA_BASE + (ADDR_W+1)'(NBITS / BYTE_W);
  localparam logic [ADDR_W:0] FLG_END = FLG_BASE + (ADDR_W+1)'(NBITS / BYTE_W);
  localparam logic [ADDR_W:0] PRT_END = PRT_BASE + (ADDR_W+1)'(NBITS);

  logic [ADDR_W:0]   addr_x;
  region_e           region;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  prt_idx, upd_idx, chg_idx;
  logic [BYTE_W-1:0] prt_rd, rd_val, rdata_q;
  logic [NBITS-1:0]  ena_vec, flg_vec;
  logic              chg, any_flag;

  assign addr_x  = {1'b0, cpu_addr_i};
  assign sel     = cpu_addr_i[SEL_W-1:0];
  assign prt_idx = cpu_addr_i[IDX_W-1:0];
  assign upd_idx = {upd_dev_i, upd_port_i};

  always_comb begin
    if      (addr_x >= PRT_BASE && addr_x < PRT_END) region = RG_PRT;
    else if (addr_x >= FLG_BASE && addr_x < FLG_END) region = RG_FLG;
    else if (addr_x >= ENA_BASE && addr_x < ENA_END) region = RG_ENA;
    else                                             region = RG_NONE;
  end

  icf_port_store #(.NBYTES(NBITS)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cpu_we_i && region == RG_PRT),
    .wr_idx_i    (prt_idx),
    .wr_data_i   (cpu_wdata_i),
    .upd_valid_i (upd_valid_i),
    .upd_idx_i   (upd_idx),
    .upd_data_i  (upd_data_i),
    .rd_idx_i    (prt_idx),
    .rd_data_o   (prt_rd),
    .chg_o       (chg),
    .chg_idx_o   (chg_idx)
  );

  icf_flag_bank #(.NBITS(NBITS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ena_we_i  (cpu_we_i && region == RG_ENA),
    .flg_we_i  (cpu_we_i && region == RG_FLG),
    .sel_i     (sel),
    .wdata_i   (cpu_wdata_i),
    .chg_i     (chg),
    .chg_idx_i (chg_idx),
    .ena_o     (ena_vec),
    .flg_o     (flg_vec),
    .any_o     (any_flag)
  );

  always_comb begin
    unique case (region)
      RG_PRT:  rd_val = prt_rd;
      RG_FLG:  rd_val = flg_vec[sel*BYTE_W +: BYTE_W];
      RG_ENA:  rd_val = ena_vec[sel*BYTE_W +: BYTE_W];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cpu_re_i) rdata_q <= rd_val;
  end

  assign cpu_rdata_o = rdata_q;
  assign irq_no      = ~any_flag;

  // R7: a qualifying change pulls the line low after the edge
  a_r7_irq_after_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && ena_vec[chg_idx]) |=> !irq_no);

  // R8: reads outside the windows return zero
  a_r8_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_re_i && region == RG_NONE) |=> (cpu_rdata_o == '0));

  // R1: idle block with no flags keeps the line high
  a_r1_irq_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_vec == '0) |-> irq_no);
endmodule

// File: tb/icf_irq_array_tb.sv
`timescale 1ns/1ps
module icf_irq_array_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0] cpu_rdata;
  logic       upd_valid = 1'b0;
  logic [5:0] upd_dev = '0;
  logic [1:0] upd_port = '0;
  logic [7:0] upd_data = '0;
  logic       irq_no;

  icf_irq_array u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_we_i(cpu_we), .cpu_re_i(cpu_re), .cpu_rdata_o(cpu_rdata),
    .upd_valid_i(upd_valid), .upd_dev_i(upd_dev), .upd_port_i(upd_port),
    .upd_data_i(upd_data), .irq_no(irq_no)
  );

  always #2 clk = ~clk;

  // reference model
  logic [7:0]   port_m [256];
  logic [255:0] en_m, flg_m;
  logic [7:0]   exp_rd;
  logic [8:0]   exp_a;
  logic         exp_v;
  string        scn = "R1";
  int           n_cmp = 0, n_bad = 0;

  function automatic logic [7:0] mread(input logic [8:0] a);
    if (a >= 9'h100)      return port_m[a[7:0]];
    else if (a >= 9'h0E0) return flg_m[a[4:0]*8 +: 8];
    else if (a >= 9'h0C0) return en_m[a[4:0]*8 +: 8];
    else                  return 8'h00;
  endfunction

  function automatic string rtag(input logic [8:0] a);
    if (a >= 9'h100)      return "R2";
    else if (a >= 9'h0E0) return "R5";
    else if (a >= 9'h0C0) return "R3";
    else                  return "R8";
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) port_m[i] = 8'h00;
      en_m  = '0;
      flg_m = '0;
      exp_v = 1'b0;
      exp_rd = '0;
      exp_a = '0;
    end else begin
      int idx;
      logic [255:0] setm, clrm;
      exp_v = cpu_re;
      exp_a = cpu_addr;
      exp_rd = mread(cpu_addr);
      idx = int'(upd_dev) * 4 + int'(upd_port);
      setm = '0;
      clrm = '0;
      if (upd_valid && en_m[idx] && upd_data != port_m[idx]) setm[idx] = 1'b1;
      if (cpu_we && cpu_addr >= 9'h0E0 && cpu_addr < 9'h100)
        for (int b = 0; b < 8; b++) if (cpu_wdata[b]) clrm[int'(cpu_addr[4:0])*8 + b] = 1'b1;
      flg_m = (flg_m & ~clrm) | setm;
      if (cpu_we && cpu_addr >= 9'h0C0 && cpu_addr < 9'h0E0) en_m[cpu_addr[4:0]*8 +: 8] = cpu_wdata;
      if (cpu_we && cpu_addr >= 9'h100) port_m[cpu_addr[7:0]] = cpu_wdata;
      if (upd_valid) port_m[idx] = upd_data;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      n_cmp++;
      if (irq_no !== (flg_m == '0)) begin
        n_bad++;
        $display("FAIL [%s] R7 irq_no actual=%b expected=%b", scn, irq_no, (flg_m == '0));
      end
      if (exp_v) begin
        n_cmp++;
        if (cpu_rdata !== exp_rd) begin
          n_bad++;
          $display("FAIL [%s] %s read %03h actual=%02h expected=%02h",
                   scn, rtag(exp_a), exp_a, cpu_rdata, exp_rd);
        end
      end
    end
  end

  task automatic step(input logic we, input logic re, input logic [8:0] a, input logic [7:0] wd,
                      input logic uv, input logic [5:0] dv, input logic [1:0] pt, input logic [7:0] ud);
    @(negedge clk);
    cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = wd;
    upd_valid = uv; upd_dev = dv; upd_port = pt; upd_data = ud;
  endtask

  task automatic rd(input logic [8:0] a);              step(0, 1, a, 8'h00, 0, 0, 0, 8'h00); endtask
  task automatic wr(input logic [8:0] a, input logic [7:0] d); step(1, 0, a, d, 0, 0, 0, 8'h00); endtask
  task automatic upd(input logic [5:0] dv, input logic [1:0] pt, input logic [7:0] d);
    step(0, 0, 9'h000, 8'h00, 1, dv, pt, d);
  endtask
  task automatic idle(); step(0, 0, 9'h000, 8'h00, 0, 0, 0, 8'h00); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    scn = "R1";
    rd(9'h000); rd(9'h050); rd(9'h0C0); rd(9'h0E0); rd(9'h100); rd(9'h1FF);
    // R2 storage from link and host
    scn = "R2";
    upd(0, 0, 8'h11); upd(5, 3, 8'hA5); upd(63, 3, 8'h3C); wr(9'h1FE, 8'h77);
    rd(9'h100); rd(9'h117); rd(9'h1FF); rd(9'h1FE); rd(9'h0E0);
    // R3 enable packing
    scn = "R3";
    wr(9'h0C0, 8'h5A); wr(9'h0C1, 8'hF0); wr(9'h0DF, 8'h81);
    rd(9'h0C0); rd(9'h0C1); rd(9'h0DF);
    // R4 set rules: change, equal value, disabled port
    scn = "R4";
    upd(0, 1, 8'h44); upd(0, 3, 8'h00); upd(0, 0, 8'h99);
    upd(63, 3, 8'h3C); upd(63, 3, 8'hC3);
    rd(9'h0E0); rd(9'h0FF); rd(9'h0E1);
    // R5 write-one-to-clear
    scn = "R5";
    wr(9'h0E0, 8'h00); rd(9'h0E0);
    wr(9'h0E0, 8'hFD); rd(9'h0E0);
    wr(9'h0E0, 8'h02); wr(9'h0FF, 8'h80);
    rd(9'h0E0); rd(9'h0FF); idle();
    // R6 set beats clear in one cycle
    scn = "R6";
    step(1, 0, 9'h0E1, 8'h40, 1, 3, 2, 8'h5E);
    rd(9'h0E1); wr(9'h0E1, 8'h40); rd(9'h0E1); idle();
    // R8 undefined range
    scn = "R8";
    wr(9'h050, 8'hFF); wr(9'h0BF, 8'hFF); wr(9'h000, 8'hFF);
    rd(9'h050); rd(9'h0BF); rd(9'h000);
    // R9 read races an update to the same byte
    scn = "R9";
    step(0, 1, 9'h100, 8'h00, 1, 0, 0, 8'h12);
    rd(9'h100);
    // R2 same-byte host and link write: link value kept
    scn = "R2";
    step(1, 0, 9'h101, 8'h55, 1, 0, 1, 8'h66);
    rd(9'h101); rd(9'h0E0);
    wr(9'h0E0, 8'hFF);
    // random traffic
    scn = "rand";
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] a;
      case ($urandom % 4)
        0: a = 9'h0C0 + 9'($urandom % 32);
        1: a = 9'h0E0 + 9'($urandom % 32);
        2: a = 9'h100 + 9'($urandom % 256);
        default: a = 9'($urandom % 192);
      endcase
      step(($urandom % 4) == 0, ($urandom % 2) == 0, a, 8'($urandom),
           ($urandom % 2) == 0, 6'($urandom), 2'($urandom), 8'($urandom % 4));
    end
    idle(); idle();
    summary();
    $finish;
  end
endmodule